// File: doc/BRIEF.md
# Scan Chain Incompatibility Detector

This block takes partially specified scan test vectors, one per handshake, as two equal-width buses: a value bus and a care bus, where a clear care bit marks the matching value bit as a don't-care. Each vector is cut into `NCHAIN` chains of `CLEN` cells. Every pair of chains is compared cell by cell under the constraint that a single scan input would load both chains with the same stream. A pair is incompatible when some cell position holds a specified 0 in one chain and a specified 1 in the other.

Flags for the pairs accumulate over a whole test set, so any vector that ever shows a pair as incompatible marks it for good. The result is a symmetric chain-by-chain matrix with a zero diagonal. Only the pairs above the diagonal are stored, and a read port returns the mirrored entry for any row and column one cycle after the address is given. A synchronous clear empties the matrix before the next test set, and a summary output tells whether any pair at all has been found incompatible. The matrix is what a later chain-grouping step takes as its input.

Top module: `chain_conflict_detector`

## Requirements
- R1: Chain c owns vector bits c*CLEN through c*CLEN+CLEN-1, and cell p of chain c is bit c*CLEN+p of both the value and care buses.
- R2: An accepted vector marks pair (i,j), i!=j, when at some cell p both chains have care=1 at p and their value bits at p differ.
- R3: A cell whose care bit is 0 never causes a mark, whatever its value bit; a vector with no care bits set changes nothing.
- R4: Marks are sticky: every accepted vector ORs its marks into the matrix until a clear.
- R5: The read flag, sampled after the clock edge that follows an address, equals the stored mark of the pair (row,col), is the same for (row,col) and (col,row), is 0 when row equals col, and is 0 when row or col is NCHAIN or larger.
- R6: A clock edge with clear high zeroes every mark, and the summary flag is 0 after that edge.
- R7: Ready is high exactly when clear is low; a vector is taken on an edge with valid and ready both high, and a vector offered while clear is high is discarded.
- R8: The summary flag is 1 exactly when at least one pair mark is set.
- R9: After reset the matrix is empty, and the summary and read flags are 0.
- R10: A vector taken on one edge is fully in the matrix and the summary flag after that edge, with no further cycles needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all pair marks |
| vec_valid | input | 1 | A vector is offered |
| vec_ready | output | 1 | A vector can be taken (low during clear) |
| vec_value | input | NCHAIN*CLEN | Value bit of every cell |
| vec_care | input | NCHAIN*CLEN | 1 = cell specified, 0 = don't-care |
| rd_row | input | $clog2(NCHAIN) | Read row (chain index) |
| rd_col | input | $clog2(NCHAIN) | Read column (chain index) |
| rd_flag | output | 1 | Registered mark of pair (rd_row, rd_col) |
| any_conflict | output | 1 | At least one pair is marked |

## Verification
The assertions rely on reset being asserted before the first vector and on the read address being held for at least the cycle that loads the read flag; they place no limit on how often vectors or clears arrive. The stimulus mixes random vectors whose care bits are set about one time in four, so that some pairs stay compatible across many vectors, with directed vectors: all don't-care, a single clash on the last cell of the first and last chains, and a clear offered together with a clashing vector. Every matrix entry is read back, including the diagonal, both orderings of each pair and out-of-range indices.

// File: rtl/scd_pkg.sv
package scd_pkg;
  // Position of pair (lo,hi), lo<hi, in the packed upper triangle
  function automatic int pair_index(input int lo, input int hi, input int nchain);
    return lo * nchain - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

  function automatic int pair_count(input int nchain);
    return (nchain * (nchain - 1)) / 2;
  endfunction
endpackage

// File: rtl/pair_compare.sv
module pair_compare #(
  parameter int CLEN = 4
) (
  input  logic [CLEN-1:0] val_a,
  input  logic [CLEN-1:0] care_a,
  input  logic [CLEN-1:0] val_b,
  input  logic [CLEN-1:0] care_b,
  output logic            clash
);
  logic [CLEN-1:0] both_set;
  logic [CLEN-1:0] differ;

  always_comb begin
    both_set = care_a & care_b;
    differ   = val_a ^ val_b;
    clash    = |(both_set & differ);
  end
endmodule

// File: rtl/conflict_matrix.sv
module conflict_matrix #(
  parameter int NPAIR = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [NPAIR-1:0] new_marks,
  output logic [NPAIR-1:0] marks,
  output logic             any_mark
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      marks    <= '0;
      any_mark <= 1'b0;
    end else if (upd) begin
      marks    <= marks | new_marks;
      any_mark <= any_mark | (|new_marks);
    end
  end

  // R6: clear empties every pair
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (marks == '0));

  // R4: no mark is lost without a clear
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && !$past(rst)) |-> ((marks & $past(marks)) == $past(marks)));

  // R8: summary flag tracks the stored pairs
  a_r8_summary: assert property (@(posedge clk) disable iff (rst)
    any_mark == (|marks));
endmodule

// File: rtl/matrix_reader.sv
module matrix_reader #(
  parameter int NCHAIN = 5,
  parameter int IW     = 3,
  parameter int NPAIR  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPAIR-1:0] marks,
  input  logic [IW-1:0]    row,
  input  logic [IW-1:0]    col,
  output logic             flag
);
  logic [NPAIR-1:0] hit;

  for (genvar gi = 0; gi < NCHAIN; gi++) begin : g_lo
    for (genvar gj = gi + 1; gj < NCHAIN; gj++) begin : g_hi
      localparam int P = scd_pkg::pair_index(gi, gj, NCHAIN);
      assign hit[P] = marks[P] &
        (((row == IW'(gi)) && (col == IW'(gj))) ||
         ((row == IW'(gj)) && (col == IW'(gi))));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= |hit;
  end

  // R5: diagonal reads as zero
  a_r5_diag_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(row) == $past(col)) |-> !flag);
endmodule

// File: rtl/chain_conflict_detector.sv
module chain_conflict_detector #(
  parameter int NCHAIN = 5,
  parameter int CLEN   = 4,
  parameter int IW     = (NCHAIN > 2) ? $clog2(NCHAIN) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   vec_valid,
  output logic                   vec_ready,
  input  logic [NCHAIN*CLEN-1:0] vec_value,
  input  logic [NCHAIN*CLEN-1:0] vec_care,
  input  logic [IW-1:0]          rd_row,
  input  logic [IW-1:0]          rd_col,
  output logic                   rd_flag,
  output logic                   any_conflict
);
  localparam int NPAIR = scd_pkg::pair_count(NCHAIN);

  logic             take;
  logic [NPAIR-1:0] vec_marks;
  logic [NPAIR-1:0] marks;

  assign vec_ready = ~clr;
  assign take      = vec_valid & vec_ready;

  for (genvar gi = 0; gi < NCHAIN; gi++) begin : g_lo
    for (genvar gj = gi + 1; gj < NCHAIN; gj++) begin : g_hi
      localparam int P = scd_pkg::pair_index(gi, gj, NCHAIN);
      pair_compare #(.CLEN(CLEN)) u_cmp (
        .val_a (vec_value[gi*CLEN +: CLEN]),
        .care_a(vec_care [gi*CLEN +: CLEN]),
        .val_b (vec_value[gj*CLEN +: CLEN]),
        .care_b(vec_care [gj*CLEN +: CLEN]),
        .clash (vec_marks[P])
      );
    end
  end

  conflict_matrix #(.NPAIR(NPAIR)) u_mat (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .upd      (take),
    .new_marks(vec_marks),
    .marks    (marks),
    .any_mark (any_conflict)
  );

  matrix_reader #(.NCHAIN(NCHAIN), .IW(IW), .NPAIR(NPAIR)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .marks(marks),
    .row  (rd_row),
    .col  (rd_col),
    .flag (rd_flag)
  );

  // R3: a vector without specified cells leaves the summary untouched
  a_r3_dontcare: assert property (@(posedge clk) disable iff (rst)
    (take && vec_care == '0 && !$past(rst)) |=> (any_conflict == $past(any_conflict)));

  // R7: a vector offered during clear is dropped
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr && vec_valid) |=> !any_conflict);

  // R9: empty after reset
  a_r9_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!any_conflict && !rd_flag));
endmodule

// File: tb/tb_chain_conflict_detector.sv
`timescale 1ns/1ps
module tb_chain_conflict_detector;
  localparam int K  = 5;
  localparam int L  = 4;
  localparam int N  = K * L;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst, clr, vec_valid, vec_ready, rd_flag, any_conflict;
  logic [N-1:0] vec_value, vec_care;
  logic [IW-1:0] rd_row, rd_col;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit expm [K][K];

  always #2 clk = ~clk;

  chain_conflict_detector #(.NCHAIN(K), .CLEN(L)) dut (
    .clk(clk), .rst(rst), .clr(clr), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_value(vec_value), .vec_care(vec_care), .rd_row(rd_row), .rd_col(rd_col),
    .rd_flag(rd_flag), .any_conflict(any_conflict)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic bit ref_clash(input logic [N-1:0] v, input logic [N-1:0] c,
                                   input int i, input int j);
    for (int p = 0; p < L; p++)
      if (c[i*L+p] && c[j*L+p] && (v[i*L+p] != v[j*L+p])) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_any();
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++)
        if (expm[i][j]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic clear_exp();
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++) expm[i][j] = 1'b0;
  endtask

  // R10: after the taking edge, matrix and summary are current
  task automatic send(input logic [N-1:0] v, input logic [N-1:0] c, input string req);
    @(negedge clk);
    vec_value = v; vec_care = c; vec_valid = 1'b1;
    @(negedge clk);
    vec_valid = 1'b0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++)
        if (i != j && ref_clash(v, c, i, j)) expm[i][j] = 1'b1;
    chk(any_conflict, exp_any(), req, "summary after vector (R8)");
  endtask

  // R5: read every entry, both orders, diagonal, out of range
  task automatic read_all(input string req);
    for (int r = 0; r < (1 << IW); r++)
      for (int cc = 0; cc < (1 << IW); cc++) begin
        rd_row = IW'(r); rd_col = IW'(cc);
        @(negedge clk);
        chk(rd_flag, (r < K && cc < K) ? expm[r][cc] : 1'b0, req,
            $sformatf("read row %0d col %0d", r, cc));
      end
  endtask

  task automatic pack(input string s, output logic [N-1:0] v, output logic [N-1:0] c);
    for (int k = 0; k < N; k++) begin
      c[k] = (s[k] != 8'h78);
      v[k] = (s[k] == 8'h31);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, c;
    void'($urandom(32'd1234));
    rst = 1'b1; clr = 1'b0; vec_valid = 1'b0;
    vec_value = '0; vec_care = '0; rd_row = '0; rd_col = '0;
    clear_exp();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(any_conflict, 1'b0, "R9", "summary after reset");
    chk(vec_ready, 1'b1, "R7", "ready with clear low");
    read_all("R9");

    // R3: all don't-care with random values
    send($urandom(), '0, "R3");
    read_all("R3");

    // R2: worked example, first vector then second
    pack("001x0xx1x01x0011xx11", v, c);
    send(v, c, "R2");
    pack("001x0xx1x11x0011xx11", v, c);
    send(v, c, "R2");
    read_all("R2");

    // R6/R7: clear together with a clashing vector
    @(negedge clk);
    clr = 1'b1; vec_valid = 1'b1; vec_value = {{(N-L){1'b0}}, {L{1'b1}}}; vec_care = '1;
    #1 chk(vec_ready, 1'b0, "R7", "ready during clear");
    @(negedge clk);
    clr = 1'b0; vec_valid = 1'b0;
    clear_exp();
    chk(any_conflict, 1'b0, "R6", "summary after clear");
    read_all("R7");

    // R1: single clash on last cell of first and last chain
    v = '0; c = '0;
    c[L-1] = 1'b1; v[L-1] = 1'b0;
    c[(K-1)*L+L-1] = 1'b1; v[(K-1)*L+L-1] = 1'b1;
    send(v, c, "R1");
    read_all("R1");

    // R4: random sparse vectors accumulate
    for (int n = 0; n < 40; n++) begin
      v = N'($urandom());
      c = N'($urandom()) & N'($urandom());
      send(v, c, "R4");
      if (n % 10 == 9) read_all("R4");
    end

    // R6: final clear
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    clear_exp();
    chk(any_conflict, 1'b0, "R6", "summary after final clear");
    read_all("R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule